// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, which of the five pipeline registers of an in-order processor (fetch, decode, execute, memory, write-back) must hold its contents (stall) and which must be loaded with a no-op (bubble). It looks at three kinds of hazard. The first is a load whose result is needed by the instruction right behind it. The second is a return instruction whose target address is not known until it reaches write-back. The third is a conditional branch that the execute stage has found to be mispredicted.

The decision is combinational, so the control signals apply at the next clock edge of the pipeline registers. Internally the unit reduces its inputs to one of four named modes. RUN means no hazard. INTERLOCK means a load/use hazard: decode is held and a bubble goes into execute. RET_HOLD means a return is in flight: fetch is held and decode gets bubbles. SQUASH means a mispredict: the two wrong-path instructions in decode and execute are cancelled. The mode is chosen in a fixed order: SQUASH first, then INTERLOCK, then RET_HOLD, then RUN. The clock and reset feed only the built-in checks.

Top module: `hazard_ctl`

## Requirements
- R1: A load/use hazard exists when the execute class is load (`e_class`=1) or pop (`e_class`=2), `e_dst` is not the no-register ID (all ones), and `e_dst` equals `d_src_a` or `d_src_b`. With no mispredict, such a hazard raises `f_stall`, `d_stall` and `e_bubble`, and leaves `d_bubble` low (INTERLOCK).
- R2: Execute classes other (0) and branch (3) never cause a load/use hazard. A destination or source equal to the no-register ID never matches.
- R3: If any of `ret_in_d`, `ret_in_e`, `ret_in_m` is high and there is neither a load/use hazard nor a mispredict, the unit raises `f_stall` and `d_bubble`, and leaves `d_stall` and `e_bubble` low (RET_HOLD).
- R4: When a load/use hazard and a return in flight occur together, the load/use response of R1 applies and `d_bubble` stays low.
- R5: `e_mispredict` high raises `d_bubble` and `e_bubble` and forces `f_stall` and `d_stall` low, whatever the other inputs are (SQUASH).
- R6: With no hazard of any kind, all ten control outputs are low (RUN).
- R7: No pipeline register ever receives stall and bubble in the same cycle.
- R8: `f_bubble`, `e_stall`, `m_stall`, `m_bubble`, `w_stall` and `w_bubble` are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| d_src_a | input | REG_W | First source register ID of the decode instruction |
| d_src_b | input | REG_W | Second source register ID of the decode instruction |
| e_class | input | 2 | Execute instruction class: 0 other, 1 load, 2 pop, 3 branch |
| e_dst | input | REG_W | Memory-result destination ID of the execute instruction |
| ret_in_d | input | 1 | A return is in decode |
| ret_in_e | input | 1 | A return is in execute |
| ret_in_m | input | 1 | A return is in memory |
| e_mispredict | input | 1 | The branch in execute was mispredicted |
| f_stall | output | 1 | Hold the fetch register |
| f_bubble | output | 1 | Bubble into the fetch register |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Bubble into the decode register |
| e_stall | output | 1 | Hold the execute register |
| e_bubble | output | 1 | Bubble into the execute register |
| m_stall | output | 1 | Hold the memory register |
| m_bubble | output | 1 | Bubble into the memory register |
| w_stall | output | 1 | Hold the write-back register |
| w_bubble | output | 1 | Bubble into the write-back register |

## Verification
The assertions assume that inputs are stable around the sampling edge. They also assume that a mispredict and a load/use hazard may appear together even though a real pipeline would never produce that, which is why every assertion names its priority explicitly. The bench changes inputs just after a rising edge and samples at the falling edge. It sweeps every class, every return-flag pattern and both mispredict values against register IDs 0, 1, 2 and the no-register ID, so matching, non-matching and no-register cases all appear on both sources.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_POP    = 2'd2,
        CLS_BRANCH = 2'd3
    } iclass_t;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_INTERLOCK,
        MODE_RET_HOLD,
        MODE_SQUASH
    } hz_mode_t;

    typedef struct packed {
        logic stall;
        logic bubble;
    } stage_ctl_t;

    localparam int NSTAGE = 5;
    localparam int ST_F   = 0;
    localparam int ST_D   = 1;
    localparam int ST_E   = 2;
    localparam int ST_M   = 3;
    localparam int ST_W   = 4;

endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [1:0]       cls,
    input  logic [REG_W-1:0] dst,
    output logic             hit
);
    localparam logic [REG_W-1:0] NO_REG = '1;

    logic from_mem;
    logic dst_valid;

    always_comb begin
        unique case (iclass_t'(cls))
            CLS_LOAD, CLS_POP:     from_mem = 1'b1;
            CLS_OTHER, CLS_BRANCH: from_mem = 1'b0;
            default:               from_mem = 1'b0;
        endcase
        dst_valid = (dst != NO_REG);
        hit = from_mem && dst_valid && ((dst == src_a) || (dst == src_b));
    end
endmodule

// File: rtl/hz_ret_track.sv
module hz_ret_track #(
    parameter int N_RET = 3
) (
    input  logic [N_RET-1:0] ret_flags,
    output logic             busy
);
    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < N_RET; i++) begin
            busy = busy | ret_flags[i];
        end
    end
endmodule

// File: rtl/hz_mode_sel.sv
module hz_mode_sel
    import hz_pkg::*;
(
    input  logic     lu_hit,
    input  logic     ret_busy,
    input  logic     mispredict,
    output hz_mode_t mode
);
    always_comb begin
        unique casez ({mispredict, lu_hit, ret_busy})
            3'b1??:  mode = MODE_SQUASH;
            3'b01?:  mode = MODE_INTERLOCK;
            3'b001:  mode = MODE_RET_HOLD;
            3'b000:  mode = MODE_RUN;
            default: mode = MODE_RUN;
        endcase
    end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] d_src_a,
    input  logic [REG_W-1:0] d_src_b,
    input  logic [1:0]       e_class,
    input  logic [REG_W-1:0] e_dst,
    input  logic             ret_in_d,
    input  logic             ret_in_e,
    input  logic             ret_in_m,
    input  logic             e_mispredict,
    output logic             f_stall,
    output logic             f_bubble,
    output logic             d_stall,
    output logic             d_bubble,
    output logic             e_stall,
    output logic             e_bubble,
    output logic             m_stall,
    output logic             m_bubble,
    output logic             w_stall,
    output logic             w_bubble
);
    localparam int N_RET = 3;

    logic       lu_hit;
    logic       ret_busy;
    hz_mode_t   mode;
    stage_ctl_t ctl [NSTAGE];

    hz_loaduse #(.REG_W(REG_W)) u_loaduse (
        .src_a (d_src_a),
        .src_b (d_src_b),
        .cls   (e_class),
        .dst   (e_dst),
        .hit   (lu_hit)
    );

    hz_ret_track #(.N_RET(N_RET)) u_ret (
        .ret_flags ({ret_in_m, ret_in_e, ret_in_d}),
        .busy      (ret_busy)
    );

    hz_mode_sel u_mode (
        .lu_hit     (lu_hit),
        .ret_busy   (ret_busy),
        .mispredict (e_mispredict),
        .mode       (mode)
    );

    always_comb begin
        for (int s = 0; s < NSTAGE; s++) begin
            ctl[s] = '{stall: 1'b0, bubble: 1'b0};
        end
        unique case (mode)
            MODE_RUN: ;
            MODE_INTERLOCK: begin
                ctl[ST_F].stall  = 1'b1;
                ctl[ST_D].stall  = 1'b1;
                ctl[ST_E].bubble = 1'b1;
            end
            MODE_RET_HOLD: begin
                ctl[ST_F].stall  = 1'b1;
                ctl[ST_D].bubble = 1'b1;
            end
            MODE_SQUASH: begin
                ctl[ST_D].bubble = 1'b1;
                ctl[ST_E].bubble = 1'b1;
            end
            default: ;
        endcase
    end

    assign f_stall  = ctl[ST_F].stall;
    assign f_bubble = ctl[ST_F].bubble;
    assign d_stall  = ctl[ST_D].stall;
    assign d_bubble = ctl[ST_D].bubble;
    assign e_stall  = ctl[ST_E].stall;
    assign e_bubble = ctl[ST_E].bubble;
    assign m_stall  = ctl[ST_M].stall;
    assign m_bubble = ctl[ST_M].bubble;
    assign w_stall  = ctl[ST_W].stall;
    assign w_bubble = ctl[ST_W].bubble;

    // R1
    interlock_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_hit && !e_mispredict) |-> (f_stall && d_stall && e_bubble && !d_bubble));

    // R3
    ret_hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_busy && !lu_hit && !e_mispredict) |-> (f_stall && d_bubble && !d_stall && !e_bubble));

    // R5
    squash_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_mispredict |-> (d_bubble && e_bubble && !f_stall && !d_stall));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lu_hit && !ret_busy && !e_mispredict) |-> (!f_stall && !d_stall && !d_bubble && !e_bubble));

    // R7
    no_dual_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_stall && d_bubble) && !(f_stall && f_bubble) && !(e_stall && e_bubble));

    // R8
    tail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_bubble || e_stall || m_stall || m_bubble || w_stall || w_bubble));

endmodule

// File: tb/hazard_ctl_bench.sv
module hazard_ctl_bench;
    localparam int REG_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] d_src_a = '0, d_src_b = '0, e_dst = '1;
    logic [1:0]       e_class = 2'd0;
    logic             ret_in_d = 1'b0, ret_in_e = 1'b0, ret_in_m = 1'b0, e_mispredict = 1'b0;
    logic f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
    logic m_stall, m_bubble, w_stall, w_bubble;

    int tests = 0;
    int failed = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hazard_ctl #(.REG_W(REG_W)) u_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .d_src_a(d_src_a), .d_src_b(d_src_b), .e_class(e_class), .e_dst(e_dst),
        .ret_in_d(ret_in_d), .ret_in_e(ret_in_e), .ret_in_m(ret_in_m),
        .e_mispredict(e_mispredict),
        .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
        .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
        .w_stall(w_stall), .w_bubble(w_bubble)
    );

    task automatic chk(input string req, input string sig, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s actual=%b expected=%b (cls=%0d dst=%0d a=%0d b=%0d ret=%b%b%b mp=%b)",
                     req, sig, act, exp, e_class, e_dst, d_src_a, d_src_b,
                     ret_in_m, ret_in_e, ret_in_d, e_mispredict);
        end
    endtask

    function automatic logic [REG_W-1:0] pick(input int i);
        case (i)
            0: return 4'd0;
            1: return 4'd1;
            2: return 4'd2;
            default: return 4'd15;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6 reset state with idle inputs
        chk("R6", "f_stall", f_stall, 1'b0);
        chk("R6", "d_stall", d_stall, 1'b0);
        chk("R6", "d_bubble", d_bubble, 1'b0);
        chk("R6", "e_bubble", e_bubble, 1'b0);
        rst_n = 1'b1;

        for (int c = 0; c < 4; c++)
        for (int di = 0; di < 4; di++)
        for (int ai = 0; ai < 4; ai++)
        for (int bi = 0; bi < 4; bi++)
        for (int r = 0; r < 8; r++)
        for (int mp = 0; mp < 2; mp++) begin
            logic lu, rb, xf_s, xd_s, xd_b, xe_b, raw_match;
            string tag;
            @(posedge clk);
            #1;
            e_class = 2'(c);
            e_dst = pick(di);
            d_src_a = pick(ai);
            d_src_b = pick(bi);
            {ret_in_m, ret_in_e, ret_in_d} = 3'(r);
            e_mispredict = mp[0];
            raw_match = (di != 3) && (di == ai || di == bi);
            lu = (c == 1 || c == 2) && raw_match;
            rb = (r != 0);
            if (mp != 0) begin
                tag = "R5"; xf_s = 0; xd_s = 0; xd_b = 1; xe_b = 1;
            end else if (lu) begin
                tag = rb ? "R4" : "R1"; xf_s = 1; xd_s = 1; xd_b = 0; xe_b = 1;
            end else if (rb) begin
                tag = "R3"; xf_s = 1; xd_s = 0; xd_b = 1; xe_b = 0;
            end else begin
                tag = (c == 0 || c == 3) && raw_match ? "R2" : "R6";
                xf_s = 0; xd_s = 0; xd_b = 0; xe_b = 0;
            end
            @(negedge clk);
            chk(tag, "f_stall", f_stall, xf_s);
            chk(tag, "d_stall", d_stall, xd_s);
            chk(tag, "d_bubble", d_bubble, xd_b);
            chk(tag, "e_bubble", e_bubble, xe_b);
            // R7: never both on one register
            chk("R7", "d_stall&d_bubble", d_stall & d_bubble, 1'b0);
            // R8: always-quiet controls
            chk("R8", "f_bubble", f_bubble, 1'b0);
            chk("R8", "e_stall", e_stall, 1'b0);
            chk("R8", "m_stall|m_bubble", m_stall | m_bubble, 1'b0);
            chk("R8", "w_stall|w_bubble", w_stall | w_bubble, 1'b0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule